// File: doc/BRIEF.md
# Status-Code Bus Command Generator

This block sits beside a processor that, instead of driving its own bus strobes, announces each bus cycle through a 3-bit status code. The generator watches that code, recognises the start of a cycle when it leaves the idle (passive) value, and then steps through the bus states T1, T2, T3, optional wait states, and T4 by itself. In each state it drives the strobes that memories, I/O devices, address latches and data transceivers need.

Read-type commands, early ("advanced") write commands and normal write commands have separate timing. This lets slow write targets see a write strobe one state sooner. A READY input stretches the cycle with wait states, and every command that is active stays held while the cycle waits.

Top module: `stat_cmd_gen`

## Requirements
- R1: While reset is asserted and after it is released with a passive code, every command output (all active low) is high and `addr_latch`, `data_en` and `dir_tx` are low.
- R2: A cycle starts only when the code sampled on a clock edge is non-passive and the code sampled on the edge before was 111. The next state is T1, and `addr_latch` is high for exactly that one state.
- R3: Code decoding: 000 interrupt acknowledge (`int_ack_n`), 001 I/O read (`io_rd_n`), 010 I/O write (`io_wr_n` plus `io_wr_adv_n`), 011 halt (no command), 100 code fetch (`mem_rd_n`), 101 memory read (`mem_rd_n`), 110 memory write (`mem_wr_n` plus `mem_wr_adv_n`), 111 passive (no cycle).
- R4: `mem_rd_n`, `io_rd_n` and `int_ack_n` are low from T2 through T3 and every wait state, and are high again in T4.
- R5: `mem_wr_adv_n` and `io_wr_adv_n` are low from T2 through the last wait state. `mem_wr_n` and `io_wr_n` are low from T3 through the last wait state, one state after the early strobe.
- R6: `data_en` is high from T2 through T4 for every code except halt, and is low outside those states.
- R7: `dir_tx` is high from T1 through T4 of I/O-write and memory-write cycles, and is low at all other times.
- R8: `ready` is sampled at the end of T3 and at the end of every wait state. When it is low, another wait state follows, with all command outputs unchanged.
- R9: No more than two command outputs are low at the same time.
- R10: A new non-passive code sampled at the end of T4 (after passive during T3) starts the next T1 immediately, with no idle state between.
- R11: A change from one non-passive code to another non-passive code, with no passive code between them, starts no cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the processor |
| rst_n | input | 1 | Asynchronous active-low reset |
| status | input | 3 | Bus status code from the processor |
| ready | input | 1 | High when the addressed target can finish the cycle |
| addr_latch | output | 1 | Address latch strobe, high in T1 |
| data_en | output | 1 | Transceiver enable |
| dir_tx | output | 1 | Transceiver direction, high for processor-to-bus |
| mem_rd_n | output | 1 | Memory read command |
| mem_wr_n | output | 1 | Memory write command |
| mem_wr_adv_n | output | 1 | Early memory write command |
| io_rd_n | output | 1 | I/O read command |
| io_wr_n | output | 1 | I/O write command |
| io_wr_adv_n | output | 1 | Early I/O write command |
| int_ack_n | output | 1 | Interrupt acknowledge command |

## Verification
The properties assume that the processor keeps the status code passive through T3 and T4, so a new cycle can only begin at the end of T4 or from idle, and that `ready` changes only between clock edges. The stimulus applies each code with a passive gap before it, and releases the code to passive once T2 has been observed. It raises `ready` on the negative edge ahead of the edge that should end the wait. One sequence deliberately holds a non-passive code and then switches to another non-passive code, to show that no cycle starts.

// File: rtl/stat_cmd_pkg.sv
package stat_cmd_pkg;
    localparam int STAT_W = 3;
    typedef logic [STAT_W-1:0] stat_t;

    localparam stat_t ST_INTA  = 3'b000;
    localparam stat_t ST_IORD  = 3'b001;
    localparam stat_t ST_IOWR  = 3'b010;
    localparam stat_t ST_HALT  = 3'b011;
    localparam stat_t ST_FETCH = 3'b100;
    localparam stat_t ST_MRD   = 3'b101;
    localparam stat_t ST_MWR   = 3'b110;
    localparam stat_t ST_IDLE  = 3'b111;

    typedef enum logic [2:0] {
        TS_IDLE, TS_T1, TS_T2, TS_T3, TS_TW, TS_T4
    } tstate_e;

    // command vector positions
    localparam int CMD_N    = 7;
    localparam int C_MRD    = 0;
    localparam int C_MWR    = 1;
    localparam int C_MWRA   = 2;
    localparam int C_IORD   = 3;
    localparam int C_IOWR   = 4;
    localparam int C_IOWRA  = 5;
    localparam int C_INTA   = 6;

    // which code owns each command
    function automatic logic cmd_owner(input int idx, input stat_t code);
        case (idx)
            C_MRD:            return (code == ST_FETCH) || (code == ST_MRD);
            C_MWR, C_MWRA:    return code == ST_MWR;
            C_IORD:           return code == ST_IORD;
            C_IOWR, C_IOWRA:  return code == ST_IOWR;
            C_INTA:           return code == ST_INTA;
            default:          return 1'b0;
        endcase
    endfunction

    // late commands only start in T3; others start in T2
    function automatic logic cmd_is_late(input int idx);
        return (idx == C_MWR) || (idx == C_IOWR);
    endfunction
endpackage

// File: rtl/stat_cmd_tstate.sv
module stat_cmd_tstate
    import stat_cmd_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  stat_t   status,
    input  logic    ready,
    output tstate_e st_d_o,
    output stat_t   code_d_o
);
    typedef struct packed {
        tstate_e st;
        stat_t   code;
        stat_t   prev;
    } trk_t;

    trk_t r_d, r_q;
    logic start;

    always_comb begin
        r_d      = r_q;
        r_d.prev = status;
        start    = ((r_q.st == TS_IDLE) || (r_q.st == TS_T4)) &&
                   (status != ST_IDLE) && (r_q.prev == ST_IDLE);
        case (r_q.st)
            TS_IDLE: r_d.st = start ? TS_T1 : TS_IDLE;
            TS_T1:   r_d.st = TS_T2;
            TS_T2:   r_d.st = TS_T3;
            TS_T3,
            TS_TW:   r_d.st = ready ? TS_T4 : TS_TW;
            TS_T4:   r_d.st = start ? TS_T1 : TS_IDLE;
            default: r_d.st = TS_IDLE;
        endcase
        if (start) begin
            r_d.code = status;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st   <= TS_IDLE;
            r_q.code <= ST_IDLE;
            r_q.prev <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign st_d_o   = r_d.st;
    assign code_d_o = r_d.code;
endmodule

// File: rtl/stat_cmd_decode.sv
module stat_cmd_decode
    import stat_cmd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  tstate_e          st_d,
    input  stat_t            code_d,
    output logic             ale_o,
    output logic             den_o,
    output logic             dtr_o,
    output logic [CMD_N-1:0] cmd_n_o
);
    typedef struct packed {
        logic             ale;
        logic             den;
        logic             dtr;
        logic [CMD_N-1:0] cmd_n;
    } out_t;

    out_t o_d, o_q;
    logic early_win, late_win, in_cycle, is_write;
    logic [CMD_N-1:0] want;

    always_comb begin
        early_win = (st_d == TS_T2) || (st_d == TS_T3) || (st_d == TS_TW);
        late_win  = (st_d == TS_T3) || (st_d == TS_TW);
        in_cycle  = (st_d != TS_IDLE);
        is_write  = (code_d == ST_MWR) || (code_d == ST_IOWR);
    end

    for (genvar i = 0; i < CMD_N; i++) begin : g_cmd
        if (cmd_is_late(i)) begin : g_late
            assign want[i] = late_win && cmd_owner(i, code_d);
        end else begin : g_early
            assign want[i] = early_win && cmd_owner(i, code_d);
        end
    end

    always_comb begin
        o_d.ale   = (st_d == TS_T1);
        o_d.den   = in_cycle && (st_d != TS_T1) && (code_d != ST_HALT);
        o_d.dtr   = in_cycle && is_write;
        o_d.cmd_n = ~want;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            o_q.ale   <= 1'b0;
            o_q.den   <= 1'b0;
            o_q.dtr   <= 1'b0;
            o_q.cmd_n <= '1;
        end else begin
            o_q <= o_d;
        end
    end

    assign ale_o   = o_q.ale;
    assign den_o   = o_q.den;
    assign dtr_o   = o_q.dtr;
    assign cmd_n_o = o_q.cmd_n;
endmodule

// File: rtl/stat_cmd_gen.sv
module stat_cmd_gen
    import stat_cmd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] status,
    input  logic       ready,
    output logic       addr_latch,
    output logic       data_en,
    output logic       dir_tx,
    output logic       mem_rd_n,
    output logic       mem_wr_n,
    output logic       mem_wr_adv_n,
    output logic       io_rd_n,
    output logic       io_wr_n,
    output logic       io_wr_adv_n,
    output logic       int_ack_n
);
    tstate_e          st_next;
    stat_t            code_next;
    logic [CMD_N-1:0] cmd_n;

    stat_cmd_tstate u_trk (
        .clk      (clk),
        .rst_n    (rst_n),
        .status   (status),
        .ready    (ready),
        .st_d_o   (st_next),
        .code_d_o (code_next)
    );

    stat_cmd_decode u_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .st_d    (st_next),
        .code_d  (code_next),
        .ale_o   (addr_latch),
        .den_o   (data_en),
        .dtr_o   (dir_tx),
        .cmd_n_o (cmd_n)
    );

    assign mem_rd_n     = cmd_n[C_MRD];
    assign mem_wr_n     = cmd_n[C_MWR];
    assign mem_wr_adv_n = cmd_n[C_MWRA];
    assign io_rd_n      = cmd_n[C_IORD];
    assign io_wr_n      = cmd_n[C_IOWR];
    assign io_wr_adv_n  = cmd_n[C_IOWRA];
    assign int_ack_n    = cmd_n[C_INTA];
endmodule

// File: rtl/stat_cmd_chk.sv
module stat_cmd_chk (
    input logic clk,
    input logic rst_n,
    input logic ready,
    input logic ale,
    input logic den,
    input logic dtr,
    input logic mrd_n,
    input logic mwr_n,
    input logic mwra_n,
    input logic iord_n,
    input logic iowr_n,
    input logic iowra_n,
    input logic inta_n
);
    // R9
    cmd_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({mrd_n, mwr_n, mwra_n, iord_n, iowr_n, iowra_n, inta_n}) >= 5);

    // R2
    ale_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> !ale);

    // R4
    rd_after_ale_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mrd_n) |-> $past(ale));

    // R5
    wr_after_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mwr_n) |-> (!mwra_n && $past(!mwra_n)));

    // R8
    wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mrd_n && $past(!mrd_n) && !ready) |=> !mrd_n);

    // R7
    dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mwr_n || !iowr_n) |-> dtr);

    // R6
    den_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mwr_n || !mrd_n || !iord_n || !iowr_n || !inta_n) |-> den);
endmodule

bind stat_cmd_gen stat_cmd_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ready   (ready),
    .ale     (addr_latch),
    .den     (data_en),
    .dtr     (dir_tx),
    .mrd_n   (mem_rd_n),
    .mwr_n   (mem_wr_n),
    .mwra_n  (mem_wr_adv_n),
    .iord_n  (io_rd_n),
    .iowr_n  (io_wr_n),
    .iowra_n (io_wr_adv_n),
    .inta_n  (int_ack_n)
);

// File: tb/sim_stat_cmd_gen.sv
module sim_stat_cmd_gen;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [2:0] status = 3'b111;
    logic ready = 1'b1;
    logic ale, den, dtr, mrd_n, mwr_n, mwra_n, iord_n, iowr_n, iowra_n, inta_n;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    stat_cmd_gen u0 (
        .clk(clk), .rst_n(rst_n), .status(status), .ready(ready),
        .addr_latch(ale), .data_en(den), .dir_tx(dtr),
        .mem_rd_n(mrd_n), .mem_wr_n(mwr_n), .mem_wr_adv_n(mwra_n),
        .io_rd_n(iord_n), .io_wr_n(iowr_n), .io_wr_adv_n(iowra_n),
        .int_ack_n(inta_n)
    );

    // reference model: 0 idle, 1 T1, 2 T2, 3 T3, 4 wait, 5 T4
    int ph = 0;
    int cd = 7;
    int prv = 7;

    always @(posedge clk) begin
        bit st;
        if (!rst_n) begin
            ph = 0; cd = 7; prv = 7;
        end else begin
            st = (ph == 0 || ph == 5) && status != 3'd7 && prv == 7;
            if (ph == 0 || ph == 5)      ph = st ? 1 : 0;
            else if (ph == 1)            ph = 2;
            else if (ph == 2)            ph = 3;
            else                         ph = ready ? 5 : 4;
            if (st) cd = int'(status);
            prv = int'(status);
        end
    end

    task automatic chk(input string nm, input string rq, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b at %0t", rq, nm, act, exp, $time);
        end
    endtask

    function automatic logic [6:0] low_set();
        return {~inta_n, ~iowra_n, ~iowr_n, ~iord_n, ~mwra_n, ~mwr_n, ~mrd_n};
    endfunction

    // per-clock comparison against the model
    always @(negedge clk) begin
        bit rdw, nww, inc;
        if (!rst_n) begin
            chk("reset cmds", "R1", &{mrd_n, mwr_n, mwra_n, iord_n, iowr_n, iowra_n, inta_n}, 1'b1);
            chk("reset ale", "R1", ale | den | dtr, 1'b0);
        end else begin
            inc = ph != 0;
            rdw = ph == 2 || ph == 3 || ph == 4;
            nww = ph == 3 || ph == 4;
            chk("ale",     "R2", ale,    ph == 1);
            chk("den",     "R6", den,    ph >= 2 && cd != 3);
            chk("dir",     "R7", dtr,    inc && (cd == 2 || cd == 6));
            chk("mem_rd",  "R4", mrd_n,  !(rdw && (cd == 4 || cd == 5)));
            chk("io_rd",   "R4", iord_n, !(rdw && cd == 1));
            chk("int_ack", "R4", inta_n, !(rdw && cd == 0));
            chk("mem_wra", "R5", mwra_n, !(rdw && cd == 6));
            chk("mem_wr",  "R5", mwr_n,  !(nww && cd == 6));
            chk("io_wra",  "R5", iowra_n,!(rdw && cd == 2));
            chk("io_wr",   "R5", iowr_n, !(nww && cd == 2));
            chk("two max", "R9", $countones(low_set()) <= 2, 1'b1);
        end
    end

    function automatic logic [6:0] t2_expect(input int c);
        case (c)
            0: return 7'b1000000;
            1: return 7'b0001000;
            2: return 7'b0100000;
            4, 5: return 7'b0000001;
            6: return 7'b0000100;
            default: return 7'b0000000;
        endcase
    endfunction

    task automatic run_cycle(input int c, input int waits);
        logic [6:0] held;
        @(negedge clk); status = 3'(c); ready = (waits == 0);
        @(negedge clk);                       // T1
        @(negedge clk);                       // T2
        n_chk++;
        if (low_set() !== t2_expect(c)) begin
            n_fail++;
            $display("FAIL R3 code %0d: actual %b expected %b", c, low_set(), t2_expect(c));
        end
        status = 3'b111;
        @(negedge clk);                       // T3
        held = low_set();
        for (int w = 0; w < waits; w++) begin
            @(negedge clk);                   // wait state
            n_chk++;
            if (low_set() !== held) begin
                n_fail++;
                $display("FAIL R8 wait %0d: actual %b expected %b", w, low_set(), held);
            end
            if (w == waits - 1) ready = 1'b1;
        end
        @(negedge clk);                       // T4
        @(negedge clk);                       // idle
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        for (int c = 0; c < 7; c++) run_cycle(c, 0);
        run_cycle(5, 2);
        run_cycle(6, 3);
        run_cycle(2, 1);
        run_cycle(0, 2);

        // R10 back-to-back
        @(negedge clk); status = 3'b110; ready = 1'b1;
        @(negedge clk);                       // T1
        @(negedge clk); status = 3'b111;      // T2
        @(negedge clk);                       // T3
        @(negedge clk); status = 3'b001;      // T4
        @(negedge clk);
        chk("back-to-back ale", "R10", ale, 1'b1);
        @(negedge clk); status = 3'b111;
        repeat (4) @(negedge clk);

        // R11 non-passive to non-passive change
        @(negedge clk); status = 3'b101;
        repeat (8) @(negedge clk);
        status = 3'b110;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("no start ale", "R11", ale, 1'b0);
            chk("no start wr", "R11", mwra_n, 1'b1);
        end
        status = 3'b111;
        repeat (3) @(negedge clk);
        run_cycle(1, 0);

        if (!done) begin
            done = 1;
            $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule